// File: doc/BRIEF.md
# ADC Scan Sequencer (SPI master)

This block is the SPI master that runs a multi-channel successive-approximation converter. The converter is controlled by single command bytes. After reset the sequencer sends three configuration bytes on its own: an internal reset, averaging off, and a setup byte that starts conversions when a conversion command is written. It then waits in idle for requests.

A request is either a single conversion (one voltage channel, or the temperature sensor) or a scan. A scan always covers channel 0 up to the highest channel set in the request mask, and can put a temperature word in front. The sequencer builds the conversion byte from the request and sends it. It then waits for the converter to finish. The wait ends on a falling edge of an active-low end-of-conversion line, with a timeout. When that line is not used, the wait is a fixed time for each converted channel. The sequencer then reads the results as big-endian 16-bit words and writes them into one result register per channel plus a temperature register. A one-cycle `done` pulse marks that the results are valid.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, and before accepting any request, the block sends three one-byte transfers in this order, with `busy` high until the last one ends:
  - 0x10: reset command, marked by bit 4.
  - 0x20: averaging command, marked by bit 5, with the lower bits zero so averaging is off.
  - 0x68: setup command, marked by bit 6. Its start-mode field in bits 5:4 is 10 (start on command write) and its reference field in bits 3:2 is 10.
- R2: A scan request sends the conversion byte with bit 7 = 1, bits 6:3 = index of the highest set bit of `req_mask`, bits 2:1 = 00 (scan from 0 up to that index) and bit 0 = `req_temp`.
- R3: A single voltage request sends bit 7 = 1, bits 6:3 = `req_chan`, bits 2:1 = 11 and bit 0 = 0. It then reads 2 bytes into that channel's result.
- R4: A single temperature request sends 0x87 whatever `req_chan` holds. It reads 4 bytes, writes the first word to `res_temp` and drops the second word.
- R5: A scan with highest index N reads 2·(N+1) bytes, plus 2 more when temperature is included. The temperature word comes first in the stream, then channels 0..N in order. Each word is received MSB first. Word k of channel c lands in `res_volt[16c+15:16c]`. Channels above N keep their old value.
- R6: With `RES_BITS` = 10 a voltage result is stored as the received word shifted right by 2. With 12 it is stored unchanged. `res_temp` is never shifted.
- R7: The SPI runs in mode 0:
  - `spi_sclk` is low whenever `spi_cs_n` is high.
  - Data is sampled on the rising edge, MSB first.
  - `spi_cs_n` stays low across every byte of one command or one read and goes high between transfers.
  - `spi_mosi` is 0 during read bytes.
- R8: With `eoc_used` = 1 the read starts only after a falling edge of `eoc_n` seen after the conversion byte. If no edge comes within `TIMEOUT` cycles, `err_timeout` is set and stays set until reset, `done` pulses and no read is made.
- R9: With `eoc_used` = 0 the read chip select falls `WAIT_PER_CH`·M + 1 cycles after the command chip select rises. M is N+1 plus 1 with temperature for a scan, and 1 for a single request.
- R10: `busy` is high from the cycle after a request is accepted until `done`. Requests presented while `busy` is high are ignored.
- R11: A scan request whose `req_mask` is zero is rejected, with or without temperature: no transfer starts and `busy` stays low.
- R12: `done` is a one-cycle pulse. It rises in the same cycle that the new results are visible and `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_scan | input | 1 | 1 = scan, 0 = single conversion |
| req_chan | input | CH_W | Channel of a single voltage request |
| req_mask | input | NUM_CH | Requested voltage channels of a scan |
| req_temp | input | 1 | Include (scan) or select (single) temperature |
| eoc_used | input | 1 | 1 = wait for end-of-conversion edge, 0 = timed wait |
| busy | output | 1 | Initialising or request in progress |
| done | output | 1 | One-cycle completion pulse |
| err_timeout | output | 1 | Sticky end-of-conversion timeout flag |
| res_volt | output | NUM_CH*16 | Per-channel results, channel c at bits 16c+15:16c |
| res_temp | output | 16 | Temperature result word |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to converter |
| spi_miso | input | 1 | Serial data from converter |
| eoc_n | input | 1 | Active-low end-of-conversion from converter |

## Verification
The bench goes after these corner cases:
- The extreme scan heights (index 0 with temperature, index 15 alone). A design that took the lowest set bit, or counted only the set bits, would send the wrong channel field and read too few bytes.
- A temperature single read with a non-zero channel input, where a leaky channel field would change the command byte or the second word would overwrite a result.
- Timeout followed by a good request. A non-sticky error flag would clear; a design that read anyway would show an extra transfer.
- The timed wait length.
- Requests presented while busy, and empty-mask scans. A design that queued or accepted them would start transfers the bench does not expect.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    // Command class is given by the highest set bit of the byte.
    localparam logic [7:0] OP_CONV  = 8'h80;
    localparam logic [7:0] OP_SETUP = 8'h40;
    localparam logic [7:0] OP_AVG   = 8'h20;
    localparam logic [7:0] OP_RESET = 8'h10;

    // Conversion byte scan field (bits 2:1).
    localparam logic [1:0] SM_UPTO  = 2'b00;
    localparam logic [1:0] SM_ONE   = 2'b11;

    // Setup byte: start mode in bits 5:4, reference selection in bits 3:2.
    localparam logic [1:0] START_ON_WRITE = 2'b10;
    localparam logic [1:0] REF_SELECT     = 2'b10;
    localparam logic [7:0] SETUP_BYTE     = OP_SETUP | {2'b00, START_ON_WRITE, REF_SELECT, 2'b00};

    typedef enum logic [2:0] {
        ST_INIT_RST,
        ST_INIT_AVG,
        ST_INIT_SETUP,
        ST_IDLE,
        ST_CONV,
        ST_WAIT,
        ST_READ
    } seq_state_e;

endpackage

// File: rtl/adc_spi_byte.sv
// One SPI mode-0 byte: MOSI shifts on falling SCLK, MISO sampled on rising.
module adc_spi_byte #(
    parameter int CLK_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx_byte
);
    localparam int DIV_W = $clog2(CLK_DIV + 1);

    typedef struct packed {
        logic             active;
        logic             sclk;
        logic [2:0]       bit_n;
        logic [DIV_W-1:0] div;
        logic [7:0]       tx;
        logic [7:0]       rx;
        logic             done;
    } eng_t;

    eng_t cur_q, nxt_d;

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.done = 1'b0;
        if (start) begin
            nxt_d.active = 1'b1;
            nxt_d.sclk   = 1'b0;
            nxt_d.bit_n  = 3'd7;
            nxt_d.div    = '0;
            nxt_d.tx     = tx_byte;
        end else if (cur_q.active) begin
            if (cur_q.div == DIV_W'(CLK_DIV - 1)) begin
                nxt_d.div = '0;
                if (!cur_q.sclk) begin
                    nxt_d.sclk = 1'b1;
                    nxt_d.rx   = {cur_q.rx[6:0], miso};
                end else begin
                    nxt_d.sclk = 1'b0;
                    nxt_d.tx   = {cur_q.tx[6:0], 1'b0};
                    if (cur_q.bit_n == 3'd0) begin
                        nxt_d.active = 1'b0;
                        nxt_d.done   = 1'b1;
                    end else begin
                        nxt_d.bit_n = cur_q.bit_n - 3'd1;
                    end
                end
            end else begin
                nxt_d.div = cur_q.div + DIV_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign sclk    = cur_q.sclk;
    assign mosi    = cur_q.tx[7];
    assign done    = cur_q.done;
    assign rx_byte = cur_q.rx;
endmodule

// File: rtl/adc_cmd_build.sv
// Derives conversion byte, read length and conversion count from a request.
module adc_cmd_build
    import adc_seq_pkg::*;
#(
    parameter int NUM_CH  = 16,
    parameter int CH_W    = 4,
    parameter int BYTE_W  = 6,
    parameter int NCONV_W = 5
) (
    input  logic               scan,
    input  logic [CH_W-1:0]    chan,
    input  logic [NUM_CH-1:0]  mask,
    input  logic               temp,
    output logic               ok,
    output logic [7:0]         cmd,
    output logic [BYTE_W-1:0]  nbytes,
    output logic [NCONV_W-1:0] nconv
);
    logic [CH_W-1:0] top_idx;
    logic [3:0]      field;
    logic [1:0]      mode;

    always_comb begin
        top_idx = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (mask[i]) top_idx = CH_W'(i);
        end
        if (scan) begin
            ok     = |mask;
            field  = 4'(top_idx);
            mode   = SM_UPTO;
            nbytes = BYTE_W'(2 * (int'(top_idx) + 1) + (temp ? 2 : 0));
            nconv  = NCONV_W'(int'(top_idx) + 1 + (temp ? 1 : 0));
        end else begin
            ok     = 1'b1;
            field  = temp ? 4'd0 : 4'(chan);
            mode   = SM_ONE;
            nbytes = temp ? BYTE_W'(4) : BYTE_W'(2);
            nconv  = NCONV_W'(1);
        end
        cmd = OP_CONV | {1'b0, field, mode, temp};
    end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_seq_pkg::*;
#(
    parameter int NUM_CH      = 16,
    parameter int RES_BITS    = 12,
    parameter int CLK_DIV     = 2,
    parameter int WAIT_PER_CH = 400,
    parameter int TIMEOUT     = 100_000_000,
    localparam int CH_W       = $clog2(NUM_CH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_scan,
    input  logic [CH_W-1:0]      req_chan,
    input  logic [NUM_CH-1:0]    req_mask,
    input  logic                 req_temp,
    input  logic                 eoc_used,
    output logic                 busy,
    output logic                 done,
    output logic                 err_timeout,
    output logic [NUM_CH*16-1:0] res_volt,
    output logic [15:0]          res_temp,
    output logic                 spi_sclk,
    output logic                 spi_cs_n,
    output logic                 spi_mosi,
    input  logic                 spi_miso,
    input  logic                 eoc_n
);
    localparam int BYTE_W  = $clog2(2 * NUM_CH + 5);
    localparam int NCONV_W = $clog2(NUM_CH + 2);
    localparam int WAIT_MX = WAIT_PER_CH * (NUM_CH + 1);
    localparam int CNT_MX  = (TIMEOUT > WAIT_MX) ? TIMEOUT : WAIT_MX;
    localparam int CNT_W   = $clog2(CNT_MX + 1);
    localparam int SHIFT   = (RES_BITS == 10) ? 2 : 0;

    typedef struct packed {
        seq_state_e               state;
        logic                     ph;
        logic                     cs_n;
        logic [CNT_W-1:0]         cnt;
        logic [CNT_W-1:0]         wait_tgt;
        logic [BYTE_W-1:0]        bidx;
        logic [BYTE_W-1:0]        nbytes;
        logic [7:0]               cmd;
        logic [7:0]               hi_byte;
        logic                     scan;
        logic                     temp;
        logic [CH_W-1:0]          chan;
        logic                     eoc_mode;
        logic [1:0]               eoc_s;
        logic                     eoc_p;
        logic                     err;
        logic                     done;
        logic [NUM_CH-1:0][15:0]  res;
        logic [15:0]              temp_res;
    } seq_t;

    seq_t cur_q, nxt_d;

    logic               bld_ok;
    logic [7:0]         bld_cmd;
    logic [BYTE_W-1:0]  bld_nbytes;
    logic [NCONV_W-1:0] bld_nconv;
    logic               sp_start, sp_done;
    logic [7:0]         sp_tx, sp_rx;

    adc_cmd_build #(
        .NUM_CH(NUM_CH), .CH_W(CH_W), .BYTE_W(BYTE_W), .NCONV_W(NCONV_W)
    ) u_build (
        .scan(req_scan), .chan(req_chan), .mask(req_mask), .temp(req_temp),
        .ok(bld_ok), .cmd(bld_cmd), .nbytes(bld_nbytes), .nconv(bld_nconv)
    );

    adc_spi_byte #(.CLK_DIV(CLK_DIV)) u_byte (
        .clk(clk), .rst_n(rst_n), .start(sp_start), .tx_byte(sp_tx),
        .miso(spi_miso), .sclk(spi_sclk), .mosi(spi_mosi),
        .done(sp_done), .rx_byte(sp_rx)
    );

    function automatic seq_t reset_value();
        seq_t v;
        v       = '0;
        v.state = ST_INIT_RST;
        v.cs_n  = 1'b1;
        v.eoc_s = 2'b11;
        v.eoc_p = 1'b1;
        return v;
    endfunction

    logic               eoc_fall;
    logic [15:0]        word;
    logic [BYTE_W-1:0]  widx;
    seq_state_e         after_cmd;
    logic [7:0]         cmd_byte;

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.done  = 1'b0;
        nxt_d.eoc_s = {cur_q.eoc_s[0], eoc_n};
        nxt_d.eoc_p = cur_q.eoc_s[1];
        eoc_fall    = cur_q.eoc_p & ~cur_q.eoc_s[1];
        sp_start    = 1'b0;
        sp_tx       = 8'h00;
        word        = {cur_q.hi_byte, sp_rx};
        widx        = cur_q.bidx >> 1;

        case (cur_q.state)
            ST_INIT_RST:   begin cmd_byte = OP_RESET;   after_cmd = ST_INIT_AVG;   end
            ST_INIT_AVG:   begin cmd_byte = OP_AVG;     after_cmd = ST_INIT_SETUP; end
            ST_INIT_SETUP: begin cmd_byte = SETUP_BYTE; after_cmd = ST_IDLE;       end
            default:       begin cmd_byte = cur_q.cmd;  after_cmd = ST_WAIT;       end
        endcase

        case (cur_q.state)
            ST_INIT_RST, ST_INIT_AVG, ST_INIT_SETUP, ST_CONV: begin
                if (!cur_q.ph) begin
                    nxt_d.cs_n = 1'b0;
                    nxt_d.ph   = 1'b1;
                    sp_start   = 1'b1;
                    sp_tx      = cmd_byte;
                end else if (sp_done) begin
                    nxt_d.cs_n  = 1'b1;
                    nxt_d.ph    = 1'b0;
                    nxt_d.cnt   = '0;
                    nxt_d.state = after_cmd;
                end
            end
            ST_IDLE: begin
                if (req_valid && bld_ok) begin
                    nxt_d.state    = ST_CONV;
                    nxt_d.ph       = 1'b0;
                    nxt_d.scan     = req_scan;
                    nxt_d.temp     = req_temp;
                    nxt_d.chan     = req_chan;
                    nxt_d.cmd      = bld_cmd;
                    nxt_d.nbytes   = bld_nbytes;
                    nxt_d.wait_tgt = CNT_W'(WAIT_PER_CH) * CNT_W'(bld_nconv);
                    nxt_d.eoc_mode = eoc_used;
                end
            end
            ST_WAIT: begin
                nxt_d.cnt = cur_q.cnt + CNT_W'(1);
                if (cur_q.eoc_mode) begin
                    if (eoc_fall) begin
                        nxt_d.state = ST_READ;
                        nxt_d.bidx  = '0;
                    end else if (cur_q.cnt == CNT_W'(TIMEOUT - 1)) begin
                        nxt_d.err   = 1'b1;
                        nxt_d.done  = 1'b1;
                        nxt_d.state = ST_IDLE;
                    end
                end else if (cur_q.cnt == cur_q.wait_tgt - CNT_W'(1)) begin
                    nxt_d.state = ST_READ;
                    nxt_d.bidx  = '0;
                end
            end
            ST_READ: begin
                if (!cur_q.ph) begin
                    nxt_d.cs_n = 1'b0;
                    nxt_d.ph   = 1'b1;
                    sp_start   = 1'b1;
                end else if (sp_done) begin
                    if (!cur_q.bidx[0]) begin
                        nxt_d.hi_byte = sp_rx;
                    end else if (cur_q.scan) begin
                        if (cur_q.temp && widx == '0) nxt_d.temp_res = word;
                        else nxt_d.res[CH_W'(widx - (cur_q.temp ? BYTE_W'(1) : BYTE_W'(0)))] = word >> SHIFT;
                    end else if (widx == '0) begin
                        if (cur_q.temp) nxt_d.temp_res = word;
                        else            nxt_d.res[cur_q.chan] = word >> SHIFT;
                    end
                    if (cur_q.bidx == cur_q.nbytes - BYTE_W'(1)) begin
                        nxt_d.cs_n  = 1'b1;
                        nxt_d.ph    = 1'b0;
                        nxt_d.done  = 1'b1;
                        nxt_d.state = ST_IDLE;
                    end else begin
                        nxt_d.bidx = cur_q.bidx + BYTE_W'(1);
                        sp_start   = 1'b1;
                    end
                end
            end
            default: nxt_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= reset_value();
        else        cur_q <= nxt_d;
    end

    assign busy        = (cur_q.state != ST_IDLE);
    assign done        = cur_q.done;
    assign err_timeout = cur_q.err;
    assign res_volt    = cur_q.res;
    assign res_temp    = cur_q.temp_res;
    assign spi_cs_n    = cur_q.cs_n;
endmodule

module adc_scan_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic err_timeout,
    input logic spi_cs_n,
    input logic spi_sclk
);
    a_r7_sclk_low_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);
    a_r12_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r12_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    a_r10_idle_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> spi_cs_n);
    a_r8_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_timeout |=> err_timeout);
endmodule

bind adc_scan_seq adc_scan_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
    .err_timeout(err_timeout), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk)
);

// File: tb/test_adc_scan_seq.sv
`timescale 1ns/1ps
module test_adc_scan_seq;
    localparam int NCH = 16;
    localparam int WPC = 40;
    localparam int TMO = 3000;

    logic clk, rst_n, req_valid, req_scan, req_temp, eoc_used;
    logic [3:0] req_chan;
    logic [NCH-1:0] req_mask;
    logic busy, done, err_timeout, spi_sclk, spi_cs_n, spi_mosi, spi_miso, eoc_n;
    logic [NCH*16-1:0] res_volt;
    logic [15:0] res_temp;

    adc_scan_seq #(.NUM_CH(NCH), .RES_BITS(10), .CLK_DIV(2), .WAIT_PER_CH(WPC), .TIMEOUT(TMO))
    i_adc_scan_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_scan(req_scan),
        .req_chan(req_chan), .req_mask(req_mask), .req_temp(req_temp), .eoc_used(eoc_used),
        .busy(busy), .done(done), .err_timeout(err_timeout), .res_volt(res_volt),
        .res_temp(res_temp), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .eoc_n(eoc_n)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    task automatic chk(input bit ok, input string tag, input string msg);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s", tag, msg);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            chk(1'b0, "watchdog", "run did not finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // ---------------- converter model ----------------
    logic [15:0] resp_w [0:17];
    logic [8:0]  bitc;
    logic [7:0]  sr, cur_first;
    int          cur_bits, cur_len;
    bit          cur_nz, in_win, eoc_auto;
    logic [7:0]  w_first [0:127];
    int          w_len [0:127];
    bit          w_nz [0:127];
    int          wcnt = 0;
    realtime     t_rise;
    int          gap_cyc;

    assign spi_miso = resp_w[bitc[8:4]][4'd15 - bitc[3:0]];

    always @(negedge spi_cs_n) begin
        in_win   = 1'b1;
        bitc     = '0;
        cur_bits = 0;
        cur_len  = 0;
        cur_nz   = 1'b0;
        gap_cyc  = int'(($realtime - t_rise) / 10.0);
    end

    always @(negedge spi_sclk) if (!spi_cs_n) bitc = bitc + 9'd1;

    always @(posedge spi_sclk) if (!spi_cs_n) begin
        sr = {sr[6:0], spi_mosi};
        cur_bits++;
        if (cur_bits % 8 == 0) begin
            cur_len++;
            if (cur_len == 1) cur_first = sr;
            else if (sr != 8'h00) cur_nz = 1'b1;
        end
    end

    always @(posedge spi_cs_n) if (in_win) begin
        in_win = 1'b0;
        t_rise = $realtime;
        if (wcnt < 128) begin
            w_first[wcnt] = cur_first;
            w_len[wcnt]   = cur_len;
            w_nz[wcnt]    = cur_nz;
        end
        wcnt++;
    end

    always @(posedge spi_cs_n) if (eoc_auto && cur_len == 1 && cur_first[7]) begin
        repeat (20) @(posedge clk);
        eoc_n <= 1'b0;
        repeat (3) @(posedge clk);
        eoc_n <= 1'b1;
    end

    // ---------------- helpers ----------------
    logic [15:0] exp_res [0:NCH-1];
    logic [15:0] exp_temp;

    task automatic fill_resp(input int seed);
        for (int i = 0; i < 18; i++) resp_w[i] = 16'(16'h1357 * (i + 1) + seed * 16'h00F1);
    endtask

    task automatic issue(input logic scan, input logic temp, input logic [3:0] chan, input logic [15:0] mask);
        @(negedge clk);
        req_scan = scan; req_temp = temp; req_chan = chan; req_mask = mask; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done(output bit seen);
        seen = 1'b0;
        for (int n = 0; n < 20000; n++) begin
            @(negedge clk);
            if (done) begin seen = 1'b1; break; end
        end
    endtask

    // Expected results from R4/R5/R6: temperature word first, voltage words shifted by 2.
    task automatic expect_update(input logic scan, input logic temp, input logic [3:0] chan, input logic [15:0] mask);
        int hi = 0;
        int k  = 0;
        if (scan) begin
            for (int i = 0; i < NCH; i++) if (mask[i]) hi = i;
            if (temp) begin exp_temp = resp_w[0]; k = 1; end
            for (int c = 0; c <= hi; c++) exp_res[c] = resp_w[k + c] >> 2;
        end else if (temp) begin
            exp_temp = resp_w[0];
        end else begin
            exp_res[chan] = resp_w[0] >> 2;
        end
    endtask

    task automatic check_results(input string tag);
        int bad = -1;
        for (int c = NCH - 1; c >= 0; c--) if (res_volt[16*c +: 16] !== exp_res[c]) bad = c;
        if (bad >= 0)
            chk(1'b0, tag, $sformatf("ch%0d act=%h exp=%h", bad, res_volt[16*bad +: 16], exp_res[bad]));
        else
            chk(1'b1, tag, "");
        chk(res_temp === exp_temp, tag, $sformatf("temp act=%h exp=%h", res_temp, exp_temp));
    endtask

    typedef struct packed {
        logic        scan;
        logic        temp;
        logic [3:0]  chan;
        logic [15:0] mask;
        logic [7:0]  cmd;
        logic [5:0]  len;
    } vec_t;

    localparam vec_t VECS [0:7] = '{
        '{1'b1, 1'b0, 4'd0,  16'h0026, 8'hA8, 6'd12},
        '{1'b1, 1'b1, 4'd0,  16'h0001, 8'h81, 6'd4},
        '{1'b1, 1'b0, 4'd0,  16'h8000, 8'hF8, 6'd32},
        '{1'b1, 1'b1, 4'd0,  16'h0900, 8'hD9, 6'd26},
        '{1'b0, 1'b0, 4'd5,  16'h0000, 8'hAE, 6'd2},
        '{1'b0, 1'b0, 4'd15, 16'h0000, 8'hFE, 6'd2},
        '{1'b0, 1'b1, 4'd9,  16'h0000, 8'h87, 6'd4},
        '{1'b0, 1'b0, 4'd0,  16'h0000, 8'h86, 6'd2}
    };

    // ---------------- main sequence ----------------
    initial begin
        bit seen;
        bit ok;
        int base;
        rst_n = 1'b0; req_valid = 1'b0; req_scan = 1'b0; req_temp = 1'b0;
        req_chan = '0; req_mask = '0; eoc_used = 1'b1; eoc_n = 1'b1; eoc_auto = 1'b1;
        in_win = 1'b0; t_rise = 0; sr = '0; cur_first = '0; bitc = '0;
        for (int c = 0; c < NCH; c++) exp_res[c] = '0;
        exp_temp = '0;
        fill_resp(0);

        repeat (5) @(negedge clk);
        // R1/R12 reset state
        chk(busy === 1'b1 && spi_cs_n === 1'b1 && done === 1'b0 && err_timeout === 1'b0,
            "R1", $sformatf("reset busy=%b cs_n=%b done=%b err=%b exp 1 1 0 0", busy, spi_cs_n, done, err_timeout));
        chk(res_volt === '0 && res_temp === '0, "R12", "results not zero in reset");
        rst_n = 1'b1;

        for (int n = 0; n < 2000 && busy; n++) @(negedge clk);
        chk(!busy, "R1", "busy still high after start-up");
        chk(wcnt == 3, "R1", $sformatf("startup transfers act=%0d exp=3", wcnt));
        chk(w_first[0] == 8'h10 && w_first[1] == 8'h20 && w_first[2] == 8'h68, "R1",
            $sformatf("startup bytes act=%h %h %h exp=10 20 68", w_first[0], w_first[1], w_first[2]));
        chk(w_len[0] == 1 && w_len[1] == 1 && w_len[2] == 1, "R7", "startup transfers not one byte each");

        // Vector table: eoc mode with the model pulsing eoc_n.
        for (int v = 0; v < 8; v++) begin
            string ctag;
            base = wcnt;
            fill_resp(v + 1);
            issue(VECS[v].scan, VECS[v].temp, VECS[v].chan, VECS[v].mask);
            wait_done(seen);
            chk(seen, "R12", $sformatf("vec %0d no done", v));
            expect_update(VECS[v].scan, VECS[v].temp, VECS[v].chan, VECS[v].mask);
            ctag = VECS[v].scan ? "R2" : (VECS[v].temp ? "R4" : "R3");
            chk(w_first[base] == VECS[v].cmd, ctag,
                $sformatf("vec %0d command act=%h exp=%h", v, w_first[base], VECS[v].cmd));
            chk(w_len[base] == 1 && w_len[base+1] == int'(VECS[v].len), "R5",
                $sformatf("vec %0d lengths act=%0d,%0d exp=1,%0d", v, w_len[base], w_len[base+1], VECS[v].len));
            chk(!w_nz[base+1], "R7", $sformatf("vec %0d mosi not zero during read", v));
            chk(gap_cyc >= 20 && gap_cyc <= 30, "R8",
                $sformatf("vec %0d eoc gap act=%0d exp 20..30", v, gap_cyc));
            check_results("R6");
            if (v == 0) begin
                @(negedge clk);
                chk(done === 1'b0, "R12", "done longer than one cycle");
            end
        end

        // R9: timed wait, scan index 2 with temperature -> 4 conversions.
        eoc_used = 1'b0; eoc_auto = 1'b0;
        base = wcnt;
        fill_resp(20);
        issue(1'b1, 1'b1, 4'd0, 16'h0004);
        wait_done(seen);
        expect_update(1'b1, 1'b1, 4'd0, 16'h0004);
        chk(seen && w_first[base] == 8'h91 && w_len[base+1] == 8, "R9",
            $sformatf("timed scan cmd act=%h exp=91 len act=%0d exp=8", w_first[base], w_len[base+1]));
        chk(gap_cyc >= 4*WPC && gap_cyc <= 4*WPC + 3, "R9",
            $sformatf("wait act=%0d exp=%0d", gap_cyc, 4*WPC + 1));
        check_results("R9");

        // R8: timeout, then sticky error.
        eoc_used = 1'b1;
        base = wcnt;
        fill_resp(30);
        issue(1'b0, 1'b0, 4'd1, 16'h0000);
        wait_done(seen);
        chk(seen && err_timeout === 1'b1, "R8", $sformatf("timeout done=%b err=%b exp 1 1", seen, err_timeout));
        chk(wcnt == base + 1, "R8", $sformatf("transfers act=%0d exp=%0d", wcnt - base, 1));
        check_results("R8");
        eoc_auto = 1'b1;
        issue(1'b0, 1'b0, 4'd1, 16'h0000);
        wait_done(seen);
        expect_update(1'b0, 1'b0, 4'd1, 16'h0000);
        chk(err_timeout === 1'b1, "R8", "error flag cleared by later request");
        check_results("R3");

        // R10: request while busy is ignored.
        base = wcnt;
        fill_resp(40);
        issue(1'b1, 1'b0, 4'd0, 16'h00FF);
        issue(1'b0, 1'b0, 4'd3, 16'h0000);
        wait_done(seen);
        expect_update(1'b1, 1'b0, 4'd0, 16'h00FF);
        chk(wcnt == base + 2 && w_first[base] == 8'hB8, "R10",
            $sformatf("busy request: transfers act=%0d exp=2 cmd act=%h exp=B8", wcnt - base, w_first[base]));
        repeat (100) @(negedge clk);
        chk(wcnt == base + 2 && !busy, "R10", $sformatf("late transfer count act=%0d exp=2", wcnt - base));
        check_results("R10");

        // R11: empty scans rejected.
        base = wcnt;
        ok = 1'b1;
        issue(1'b1, 1'b0, 4'd0, 16'h0000);
        for (int n = 0; n < 40; n++) begin @(negedge clk); if (busy || done) ok = 1'b0; end
        issue(1'b1, 1'b1, 4'd0, 16'h0000);
        for (int n = 0; n < 40; n++) begin @(negedge clk); if (busy || done) ok = 1'b0; end
        chk(ok, "R11", "empty scan accepted");
        chk(wcnt == base, "R11", $sformatf("transfers act=%0d exp=0", wcnt - base));
        check_results("R11");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule